// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a small 32-bit load/store processor. Thirty physical general-purpose words sit behind the fifteen names r0 to r14. The current processor mode decides which physical word each name selects, so an exception handler gets its own stack pointer and link register, and the fast-interrupt mode also gets private copies of r8 to r12. Changing mode therefore takes no register spills. Name r15 is the program counter. When it is read through a data port, the value returned is ahead of the executing instruction by the pipeline offset.

The block also holds the current status word and one saved status word for each of the five exception modes. The status word carries the condition flags, the interrupt masks, the instruction-width state and the mode. An exception-entry request acts in a single cycle. It saves the status word, sets the new mode and masks, stores a return address in the new bank's r14 and loads the vector into the program counter. The decoder drives two combinational read ports and one clocked write port, and it uses a step strobe to advance the program counter.

Top module: `bank_regfile`

## Requirements
- R1: After synchronous reset the program counter is 0 and the status word is 0x000000D3 (Supervisor mode, both interrupt masks set, 32-bit state, flags clear). The saved status words reset to 0.
- R2: Status bits [4:0] hold the mode: 10000 User, 10001 fast interrupt, 10010 interrupt, 10011 Supervisor, 10111 Abort, 11011 Undefined, 11111 System. User and System share one bank. The fast-interrupt mode has private r8–r14. The other four exception modes each have private r13–r14. Every other name maps to the User word, and an unlisted mode code maps like User.
- R3: Reading name 15 on either port returns the program counter plus 8 when status bit 5 (instruction-width state) is 0, and plus 4 when it is 1.
- R4: While the step strobe is high, with no r15 write and no exception, the program counter advances by 4 when bit 5 is 0 and by 2 when it is 1.
- R5: A port write to name 15 loads the program counter with the write data, and this takes priority over the step strobe.
- R6: An exception request whose target is one of the five exception modes acts on the next edge. The old status word goes into the target's saved slot. The target's r14 receives the return address and the program counter receives the vector. Mode becomes the target, bit 7 (interrupt mask) is set, bit 6 (fast-interrupt mask) is set only for a fast-interrupt target, bit 5 is cleared, and bits [31:28] (flags) are kept. A status or saved-status write in the same cycle is dropped.
- R7: A register write presented in the same cycle as an exception entry lands in the bank of the mode that was active before the entry.
- R8: In User, System or an unlisted mode the saved-status port reads 0, and a write to it changes no saved slot.
- R9: A status write replaces the whole status word on the next edge.
- R10: The two read ports are combinational and independent, and each can address any name in the same cycle as the other.
- R11: A register write becomes visible only after the clock edge. Before that edge, a read of the same name returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_sel | input | 4 | Read port A register name |
| ra_data | output | 32 | Read port A data |
| rb_sel | input | 4 | Read port B register name |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register write name |
| wr_data | input | 32 | Register write data |
| pc_step | input | 1 | Sequential program-counter advance |
| exec_pc | output | 32 | Address of the executing instruction |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | Status word write data |
| stat_q | output | 32 | Current status word |
| saved_wr_en | input | 1 | Saved status write enable (current mode's slot) |
| saved_wr_data | input | 32 | Saved status write data |
| saved_q | output | 32 | Saved status word of the current mode |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the exception |
| exc_vector | input | 32 | Handler address loaded into the program counter |
| exc_ret | input | 32 | Return address stored in the target's r14 |

## Verification
A bank-map fault leaves stat_q correct but puts a wrong value on a read port. That value appears only when a name is read after the mode has changed, so the bench writes a distinct pattern into every bank and reads each one back after switching modes. A fault in the saved-status or exception path shows on saved_q, stat_q and exec_pc in the cycle right after the entry edge. A wrong program-counter increment or r15 offset shows on exec_pc or the r15 read after one step.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
  localparam int MODE_W   = 5;
  localparam int NAME_W   = 4;
  localparam int PHYS_GPR = 30;
  localparam int PHYS_W   = $clog2(PHYS_GPR);
  localparam int NUM_SAVED = 5;
  localparam int SLOT_W   = $clog2(NUM_SAVED);

  localparam logic [MODE_W-1:0] M_USER     = 5'b10000;
  localparam logic [MODE_W-1:0] M_FAST_IRQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ      = 5'b10010;
  localparam logic [MODE_W-1:0] M_SUPER    = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABORT    = 5'b10111;
  localparam logic [MODE_W-1:0] M_UNDEF    = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYSTEM   = 5'b11111;

  // status word field positions
  localparam int ST_T = 5;
  localparam int ST_F = 6;
  localparam int ST_I = 7;

  function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
    return (m == M_FAST_IRQ) || (m == M_IRQ) || (m == M_SUPER) ||
           (m == M_ABORT) || (m == M_UNDEF);
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
    case (m)
      M_FAST_IRQ: return SLOT_W'(0);
      M_IRQ:      return SLOT_W'(1);
      M_SUPER:    return SLOT_W'(2);
      M_ABORT:    return SLOT_W'(3);
      M_UNDEF:    return SLOT_W'(4);
      default:    return SLOT_W'(0);
    endcase
  endfunction

  // physical layout: 0..14 shared, 15..21 fast r8-r14,
  // 22/23 irq, 24/25 super, 26/27 abort, 28/29 undef (r13, r14)
  function automatic logic [PHYS_W-1:0] phys_of(input logic [MODE_W-1:0] m,
                                                input logic [NAME_W-1:0] n);
    logic [PHYS_W-1:0] base;
    base = PHYS_W'(n);
    case (m)
      M_FAST_IRQ: return (n >= 4'd8)  ? base + PHYS_W'(7)  : base;
      M_IRQ:      return (n >= 4'd13) ? base + PHYS_W'(9)  : base;
      M_SUPER:    return (n >= 4'd13) ? base + PHYS_W'(11) : base;
      M_ABORT:    return (n >= 4'd13) ? base + PHYS_W'(13) : base;
      M_UNDEF:    return (n >= 4'd13) ? base + PHYS_W'(15) : base;
      default:    return base;
    endcase
  endfunction
endpackage

// File: rtl/brf_bank_map.sv
`timescale 1ns/1ps
module brf_bank_map
  import brf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [NAME_W-1:0] name,
  output logic [PHYS_W-1:0] phys
);
  always_comb phys = phys_of(mode, name);
endmodule

// File: rtl/brf_gpr_store.sv
`timescale 1ns/1ps
module brf_gpr_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int NRD    = 2
) (
  input  logic                              clk,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0] rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]        rd_data,
  input  logic                              wa_en,
  input  logic [$clog2(DEPTH)-1:0]          wa_addr,
  input  logic [DATA_W-1:0]                 wa_data,
  input  logic                              wb_en,
  input  logic [$clog2(DEPTH)-1:0]          wb_addr,
  input  logic [DATA_W-1:0]                 wb_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // port b (exception link) is applied last and wins a collision
  always_ff @(posedge clk) begin
    if (wa_en) mem[wa_addr] <= wa_data;
    if (wb_en) mem[wb_addr] <= wb_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/brf_pc_unit.sv
`timescale 1ns/1ps
module brf_pc_unit #(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_go,
  input  logic [DATA_W-1:0] exc_vector,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              step,
  input  logic              narrow,
  output logic [DATA_W-1:0] pc_q
);
  localparam logic [DATA_W-1:0] INC_WIDE   = DATA_W'(4);
  localparam logic [DATA_W-1:0] INC_NARROW = DATA_W'(2);

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RESET_PC;
    else if (exc_go)  pc_q <= exc_vector;
    else if (load_en) pc_q <= load_data;
    else if (step)    pc_q <= pc_q + (narrow ? INC_NARROW : INC_WIDE);
  end
endmodule

// File: rtl/brf_status_unit.sv
`timescale 1ns/1ps
module brf_status_unit
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_wr_en,
  input  logic [DATA_W-1:0] stat_wr_data,
  input  logic              saved_wr_en,
  input  logic [DATA_W-1:0] saved_wr_data,
  input  logic              exc_go,
  input  logic [MODE_W-1:0] exc_mode,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] saved_q
);
  localparam logic [DATA_W-1:0] RESET_PSR = DATA_W'(8'hD3);

  logic [DATA_W-1:0]                 psr_r;
  logic [NUM_SAVED-1:0][DATA_W-1:0]  sav_r;
  logic [DATA_W-1:0]                 entry_psr;
  logic [MODE_W-1:0]                 cur_mode;
  logic                              cur_has_slot;
  logic [SLOT_W-1:0]                 cur_slot;
  logic [SLOT_W-1:0]                 tgt_slot;

  assign cur_mode     = psr_r[MODE_W-1:0];
  assign cur_has_slot = is_exc_mode(cur_mode);
  assign cur_slot     = saved_slot(cur_mode);
  assign tgt_slot     = saved_slot(exc_mode);

  always_comb begin
    entry_psr               = psr_r;
    entry_psr[MODE_W-1:0]   = exc_mode;
    entry_psr[ST_T]         = 1'b0;
    entry_psr[ST_I]         = 1'b1;
    if (exc_mode == M_FAST_IRQ) entry_psr[ST_F] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_r <= RESET_PSR;
      sav_r <= '0;
    end else if (exc_go) begin
      psr_r           <= entry_psr;
      sav_r[tgt_slot] <= psr_r;
    end else begin
      if (stat_wr_en) psr_r <= stat_wr_data;
      if (saved_wr_en && cur_has_slot) sav_r[cur_slot] <= saved_wr_data;
    end
  end

  assign stat_q  = psr_r;
  assign saved_q = cur_has_slot ? sav_r[cur_slot] : '0;
endmodule

// File: rtl/bank_regfile.sv
`timescale 1ns/1ps
module bank_regfile
  import brf_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        ra_sel,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_sel,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_step,
  output logic [DATA_W-1:0] exec_pc,
  input  logic              stat_wr_en,
  input  logic [DATA_W-1:0] stat_wr_data,
  output logic [DATA_W-1:0] stat_q,
  input  logic              saved_wr_en,
  input  logic [DATA_W-1:0] saved_wr_data,
  output logic [DATA_W-1:0] saved_q,
  input  logic              exc_req,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_vector,
  input  logic [DATA_W-1:0] exc_ret
);
  localparam int NRD = 2;
  localparam logic [NAME_W-1:0] PC_NAME   = '1;
  localparam logic [NAME_W-1:0] LINK_NAME = NAME_W'(14);
  localparam logic [DATA_W-1:0] AHEAD_WIDE   = DATA_W'(8);
  localparam logic [DATA_W-1:0] AHEAD_NARROW = DATA_W'(4);

  logic                          exc_go;
  logic [MODE_W-1:0]             cur_mode;
  logic                          narrow;
  logic [DATA_W-1:0]             pc_q;
  logic [DATA_W-1:0]             pc_ahead;
  logic [NRD-1:0][NAME_W-1:0]    rsel;
  logic [NRD-1:0][PHYS_W-1:0]    rphys;
  logic [NRD-1:0][DATA_W-1:0]    rraw;
  logic [NRD-1:0][DATA_W-1:0]    rout;
  logic [PHYS_W-1:0]             wphys;
  logic [PHYS_W-1:0]             lphys;
  logic                          gpr_we;
  logic                          pc_we;

  assign exc_go   = exc_req && is_exc_mode(exc_mode);
  assign cur_mode = stat_q[MODE_W-1:0];
  assign narrow   = stat_q[ST_T];
  assign pc_ahead = pc_q + (narrow ? AHEAD_NARROW : AHEAD_WIDE);
  assign gpr_we   = wr_en && (wr_sel != PC_NAME);
  assign pc_we    = wr_en && (wr_sel == PC_NAME);
  assign rsel     = {rb_sel, ra_sel};

  for (genvar g = 0; g < NRD; g++) begin : g_rport
    brf_bank_map u_map (
      .mode (cur_mode),
      .name (rsel[g]),
      .phys (rphys[g])
    );
    assign rout[g] = (rsel[g] == PC_NAME) ? pc_ahead : rraw[g];
  end

  assign ra_data = rout[0];
  assign rb_data = rout[1];

  brf_bank_map u_wmap (
    .mode (cur_mode),
    .name (wr_sel),
    .phys (wphys)
  );

  brf_bank_map u_lmap (
    .mode (exc_mode),
    .name (LINK_NAME),
    .phys (lphys)
  );

  brf_gpr_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_GPR),
    .NRD    (NRD)
  ) u_store (
    .clk     (clk),
    .rd_addr (rphys),
    .rd_data (rraw),
    .wa_en   (gpr_we),
    .wa_addr (wphys),
    .wa_data (wr_data),
    .wb_en   (exc_go),
    .wb_addr (lphys),
    .wb_data (exc_ret)
  );

  brf_pc_unit #(
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk        (clk),
    .rst        (rst),
    .exc_go     (exc_go),
    .exc_vector (exc_vector),
    .load_en    (pc_we),
    .load_data  (wr_data),
    .step       (pc_step),
    .narrow     (narrow),
    .pc_q       (pc_q)
  );

  brf_status_unit #(
    .DATA_W (DATA_W)
  ) u_status (
    .clk           (clk),
    .rst           (rst),
    .stat_wr_en    (stat_wr_en),
    .stat_wr_data  (stat_wr_data),
    .saved_wr_en   (saved_wr_en),
    .saved_wr_data (saved_wr_data),
    .exc_go        (exc_go),
    .exc_mode      (exc_mode),
    .stat_q        (stat_q),
    .saved_q       (saved_q)
  );

  assign exec_pc = pc_q;
endmodule

// File: rtl/brf_checker.sv
`timescale 1ns/1ps
module brf_checker
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        ra_sel,
  input logic [DATA_W-1:0] ra_data,
  input logic              wr_en,
  input logic [3:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_step,
  input logic [DATA_W-1:0] exec_pc,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] saved_q,
  input logic              exc_req,
  input logic [4:0]        exc_mode,
  input logic [DATA_W-1:0] exc_vector
);
  logic entering;
  logic pc_written;
  assign entering   = exc_req && is_exc_mode(exc_mode);
  assign pc_written = wr_en && (wr_sel == 4'hF);

  AST_R15_AHEAD: assert property (@(posedge clk) disable iff (rst)
    (ra_sel == 4'hF) |-> ra_data == exec_pc + (stat_q[ST_T] ? DATA_W'(4) : DATA_W'(8))); // R3

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (pc_step && !entering && !pc_written) |=>
      exec_pc == $past(exec_pc) + ($past(stat_q[ST_T]) ? DATA_W'(2) : DATA_W'(4))); // R4

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (pc_written && !entering) |=> exec_pc == $past(wr_data)); // R5

  AST_EXC_ENTRY: assert property (@(posedge clk) disable iff (rst)
    entering |=> (stat_q[MODE_W-1:0] == $past(exc_mode)) && stat_q[ST_I] && !stat_q[ST_T] &&
                 (exec_pc == $past(exc_vector)) && (saved_q == $past(stat_q)) &&
                 (stat_q[DATA_W-1:DATA_W-4] == $past(stat_q[DATA_W-1:DATA_W-4]))); // R6

  AST_NO_SAVED_SLOT: assert property (@(posedge clk) disable iff (rst)
    !is_exc_mode(stat_q[MODE_W-1:0]) |-> saved_q == '0); // R8
endmodule

bind bank_regfile brf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ra_sel     (ra_sel),
  .ra_data    (ra_data),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .pc_step    (pc_step),
  .exec_pc    (exec_pc),
  .stat_q     (stat_q),
  .saved_q    (saved_q),
  .exc_req    (exc_req),
  .exc_mode   (exc_mode),
  .exc_vector (exc_vector)
);

// File: tb/bank_regfile_bench.sv
`timescale 1ns/1ps
module bank_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ra_sel = '0, rb_sel = '0, wr_sel = '0;
  logic [31:0] ra_data, rb_data, exec_pc, stat_q, saved_q;
  logic        wr_en = 1'b0, pc_step = 1'b0, stat_wr_en = 1'b0;
  logic        saved_wr_en = 1'b0, exc_req = 1'b0;
  logic [31:0] wr_data = '0, stat_wr_data = '0, saved_wr_data = '0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] exc_vector = '0, exc_ret = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk(clk), .rst(rst),
    .ra_sel(ra_sel), .ra_data(ra_data), .rb_sel(rb_sel), .rb_data(rb_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_step(pc_step), .exec_pc(exec_pc),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_q(stat_q),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_q(saved_q),
    .exc_req(exc_req), .exc_mode(exc_mode), .exc_vector(exc_vector), .exc_ret(exc_ret)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] b);
    ra_sel = a;
    rb_sel = b;
    #1;
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_stat(input logic [31:0] v);
    stat_wr_en = 1'b1; stat_wr_data = v;
    tick();
    stat_wr_en = 1'b0;
    #1;
    chk("R9 status write", stat_q, v);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 pc", exec_pc, 32'h0);
    chk("R1 status", stat_q, 32'h0000_00D3);
    chk("R1 saved", saved_q, 32'h0);
  endtask

  task automatic t_banking();
    set_stat(32'h10);
    for (int i = 0; i < 15; i++) wr(4'(i), 32'h1000 + i);
    for (int i = 0; i < 15; i++) begin
      rd(4'(i), 4'(14 - i));
      chk("R10 port A user", ra_data, 32'h1000 + i);
      chk("R10 port B user", rb_data, 32'h1000 + 14 - i);
    end
    set_stat(32'h11);
    for (int i = 8; i < 15; i++) wr(4'(i), 32'h2000 + i);
    rd(4'd7, 4'd8);
    chk("R2 fast r7 shared", ra_data, 32'h1007);
    chk("R2 fast r8 private", rb_data, 32'h2008);
    rd(4'd14, 4'd12);
    chk("R2 fast r14", ra_data, 32'h200E);
    chk("R2 fast r12", rb_data, 32'h200C);
    set_stat(32'h12);
    wr(4'd13, 32'h3000D);
    wr(4'd14, 32'h3000E);
    rd(4'd12, 4'd13);
    chk("R2 irq r12 shared", ra_data, 32'h100C);
    chk("R2 irq r13 private", rb_data, 32'h3000D);
    set_stat(32'h1F);
    rd(4'd13, 4'd8);
    chk("R2 system r13 = user", ra_data, 32'h100D);
    chk("R2 system r8 = user", rb_data, 32'h1008);
    set_stat(32'h14);
    rd(4'd14, 4'd0);
    chk("R2 unlisted mode r14 = user", ra_data, 32'h100E);
    set_stat(32'h11);
    rd(4'd13, 4'd0);
    chk("R2 fast r13 kept", ra_data, 32'h200D);
  endtask

  task automatic t_sync_write();
    set_stat(32'h10);
    wr_en = 1'b1; wr_sel = 4'd3; wr_data = 32'hABCD;
    rd(4'd3, 4'd3);
    chk("R11 old value before edge", ra_data, 32'h1003);
    tick();
    wr_en = 1'b0;
    #1;
    chk("R11 new value after edge", rb_data, 32'hABCD);
  endtask

  task automatic t_pc();
    #1;
    chk("R4 pc start", exec_pc, 32'h0);
    pc_step = 1'b1;
    repeat (3) tick();
    pc_step = 1'b0;
    rd(4'd15, 4'd0);
    chk("R4 wide step", exec_pc, 32'd12);
    chk("R3 wide r15 read", ra_data, 32'd20);
    set_stat(32'h30);
    pc_step = 1'b1;
    repeat (2) tick();
    pc_step = 1'b0;
    rd(4'd0, 4'd15);
    chk("R4 narrow step", exec_pc, 32'd16);
    chk("R3 narrow r15 read", rb_data, 32'd20);
  endtask

  task automatic t_pc_load();
    pc_step = 1'b1;
    wr(4'd15, 32'h400);
    pc_step = 1'b0;
    #1;
    chk("R5 pc load beats step", exec_pc, 32'h400);
    set_stat(32'h10);
  endtask

  task automatic t_exception();
    set_stat(32'hA000_0010);
    exc_req = 1'b1; exc_mode = 5'b10010; exc_vector = 32'h18; exc_ret = 32'h1234;
    wr_en = 1'b1; wr_sel = 4'd14; wr_data = 32'h5555;
    tick();
    exc_req = 1'b0; wr_en = 1'b0;
    rd(4'd14, 4'd13);
    chk("R6 irq entry status", stat_q, 32'hA000_0092);
    chk("R6 irq entry pc", exec_pc, 32'h18);
    chk("R6 irq saved status", saved_q, 32'hA000_0010);
    chk("R6 irq r14 link", ra_data, 32'h1234);
    chk("R6 irq r13 untouched", rb_data, 32'h3000D);
    set_stat(32'h10);
    rd(4'd14, 4'd0);
    chk("R7 write landed in old bank", ra_data, 32'h5555);
    set_stat(32'h30);
    exc_req = 1'b1; exc_mode = 5'b10001; exc_vector = 32'h1C; exc_ret = 32'h77;
    stat_wr_en = 1'b1; stat_wr_data = 32'hFFFF_FFFF;
    tick();
    exc_req = 1'b0; stat_wr_en = 1'b0;
    rd(4'd14, 4'd8);
    chk("R6 fast entry status, status write dropped", stat_q, 32'h0000_00D1);
    chk("R6 fast saved status", saved_q, 32'h30);
    chk("R6 fast r14 link", ra_data, 32'h77);
    chk("R6 fast pc", exec_pc, 32'h1C);
    chk("R6 fast r8 untouched", rb_data, 32'h2008);
  endtask

  task automatic t_saved();
    set_stat(32'h10);
    saved_wr_en = 1'b1; saved_wr_data = 32'hDEAD_BEEF;
    tick();
    saved_wr_en = 1'b0;
    #1;
    chk("R8 user saved reads zero", saved_q, 32'h0);
    set_stat(32'h1F);
    chk("R8 system saved reads zero", saved_q, 32'h0);
    set_stat(32'h12);
    chk("R8 irq slot unchanged by user write", saved_q, 32'hA000_0010);
    set_stat(32'h11);
    chk("R8 fast slot unchanged by user write", saved_q, 32'h30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_banking();
    t_sync_write();
    t_pc();
    t_pc_load();
    t_exception();
    t_saved();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule